// File: doc/BRIEF.md
# Endpoint Configuration and Status Register Block

This block keeps the configuration and status of one endpoint in a USB device controller. Software programs an endpoint size code and a bank count, then sets an allocate bit. On the cycle the allocate bit goes from 0 to 1, the block multiplies the endpoint size by the bank count. It compares the product with the FIFO capacity, and it compares the bank count with the largest bank count allowed. The result is latched into a configuration-valid flag. The allocate state is also driven out to the FIFO manager.

The packet engine reports four kinds of event: isochronous overflow, isochronous underflow, a filtered zero-length packet, and the data toggle of a received packet. The three events become sticky flags. Only hardware sets them and only software clears them. A write of 0 to a flag clears it and a write of 1 leaves it as it is. The two error flags, each gated by its own enable bit, drive a level interrupt. A two-bit toggle field holds the toggle of the last packet received on the current bank.

Top module: `ep_status_cfg`

## Requirements
- R1: The control register at address 0 holds the allocate bit in bit 0. It reads back as written and drives `ep_alloc`.
- R2: The configuration-valid flag is status bit 0. It is updated only on a write that moves the allocate bit from 0 to 1. It becomes 1 exactly when (BASE_BYTES << size code) × (bank field + 1) ≤ FIFO_BYTES and (bank field + 1) ≤ MAX_BANKS. Otherwise it holds its value. The size code is bits 2:0 of the config register at address 1, and the bank field is bits 5:4 of that register.
- R3: An `ovf_evt` pulse sets the overflow flag (status bit 1) on the next clock edge, and the flag stays set.
- R4: A `udf_evt` pulse sets the underflow flag (status bit 2) on the next clock edge, and the flag stays set.
- R5: A `zlp_evt` pulse sets the zero-length-packet flag (status bit 3) on the next clock edge, and the flag stays set.
- R6: A write to the status register at address 2 clears each flag whose data bit is 0. A data bit of 1 leaves its flag unchanged. Software can never set a flag.
- R7: When a hardware event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R8: `ep_irq` = (overflow AND enable bit 0) OR (underflow AND enable bit 1). The enables are in the register at address 3. The zero-length-packet flag never raises `ep_irq`.
- R9: A cycle with `rx_tog_vld` high loads status bits 5:4 with {0, `rx_tog`}, where 00 means DATA0 and 01 means DATA1. The field is read-only to software.
- R10: All registers reset to 0. Reserved bits read 0: control bits 7:1, config bits 7:6 and 3, status bits 7:6, and enable bits 7:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| ovf_evt | input | 1 | Isochronous overflow event |
| udf_evt | input | 1 | Isochronous underflow event |
| zlp_evt | input | 1 | Zero-length packet filtered |
| rx_tog_vld | input | 1 | Received data toggle is valid |
| rx_tog | input | 1 | Received data toggle (0 = DATA0, 1 = DATA1) |
| ep_alloc | output | 1 | Endpoint memory allocated |
| ep_irq | output | 1 | Endpoint interrupt, level |

## Verification
Some rules are checked by the in-module assertions on every cycle:
- the configuration-valid flag never moves outside an allocation rise;
- a hardware event always leaves its flag set, including against a same-cycle clear;
- a flag never rises without an event, and holds unless a clear arrives;
- the toggle field captures the received toggle;
- the interrupt stays low with both enables clear;
- the allocate bit follows control writes.

The capacity arithmetic itself is shown only by the bench's table of size/bank vectors. That table covers exact-fit, over-capacity and too-many-banks cases. The bench also shows that writes of 1 to the flags and writes to the toggle field have no effect. The reserved-bit masking and the interrupt masking of the zero-length-packet flag are also covered only by the bench.

// File: rtl/ep_stat_pkg.sv
package ep_stat_pkg;
  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_CFG  = 2'd1,
    RA_STAT = 2'd2,
    RA_IEN  = 2'd3
  } reg_addr_e;

  localparam int unsigned SIZE_W  = 3;
  localparam int unsigned BANK_W  = 2;
  localparam int unsigned NFLAG   = 3;
  localparam int unsigned FL_OVF  = 0;
  localparam int unsigned FL_UDF  = 1;
  localparam int unsigned FL_ZLP  = 2;
  localparam int unsigned ST_OK   = 0;
  localparam int unsigned ST_FLG0 = 1;
  localparam int unsigned ST_TOG0 = 4;
  localparam int unsigned CF_BNK0 = 4;
endpackage

// File: rtl/ep_cfg_check.sv
module ep_cfg_check
  import ep_stat_pkg::*;
#(
  parameter int unsigned FIFO_BYTES = 256,
  parameter int unsigned MAX_BANKS  = 2,
  parameter int unsigned BASE_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_rise,
  input  logic [SIZE_W-1:0] size_code,
  input  logic [BANK_W-1:0] bank_sel,
  output logic              cfg_ok
);
  localparam logic [31:0] CAP  = 32'(FIFO_BYTES);
  localparam logic [31:0] MAXB = 32'(MAX_BANKS);
  localparam logic [31:0] BASE = 32'(BASE_BYTES);

  logic [31:0] ep_bytes;
  logic [31:0] bank_cnt;
  logic [31:0] need_bytes;
  logic        fits;
  logic        cfg_ok_d;
  logic        cfg_ok_q;

  always_comb begin
    ep_bytes   = BASE << size_code;
    bank_cnt   = 32'(bank_sel) + 32'd1;
    need_bytes = ep_bytes * bank_cnt;
    fits       = (need_bytes <= CAP) && (bank_cnt <= MAXB);
    cfg_ok_d   = cfg_ok_q;
    if (alloc_rise) cfg_ok_d = fits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_ok_q <= 1'b0;
    else        cfg_ok_q <= cfg_ok_d;
  end

  assign cfg_ok = cfg_ok_q;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_rise |=> $stable(cfg_ok_q)); // R2
endmodule

// File: rtl/ep_sticky_flags.sv
module ep_sticky_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hw_set,
  input  logic [N-1:0] sw_clr,
  output logic [N-1:0] flags
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic q;
    logic d;

    always_comb begin
      d = q;
      if (sw_clr[g]) d = 1'b0;
      if (hw_set[g]) d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
    end

    assign flags[g] = q;

    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set[g] |=> q); // R7
    AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!q && !hw_set[g]) |=> !q); // R6
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !sw_clr[g]) |=> q); // R3
  end
endmodule

// File: rtl/ep_toggle_track.sv
module ep_toggle_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vld,
  input  logic       rx_tog,
  output logic [1:0] toggle
);
  logic [1:0] tog_d;
  logic [1:0] tog_q;

  always_comb begin
    tog_d = tog_q;
    if (vld) tog_d = {1'b0, rx_tog};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 2'b00;
    else        tog_q <= tog_d;
  end

  assign toggle = tog_q;

  AST_TOG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> (toggle == {1'b0, $past(rx_tog)})); // R9
endmodule

// File: rtl/ep_status_cfg.sv
module ep_status_cfg
  import ep_stat_pkg::*;
#(
  parameter int unsigned FIFO_BYTES = 256,
  parameter int unsigned MAX_BANKS  = 2,
  parameter int unsigned BASE_BYTES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       ovf_evt,
  input  logic       udf_evt,
  input  logic       zlp_evt,
  input  logic       rx_tog_vld,
  input  logic       rx_tog,
  output logic       ep_alloc,
  output logic       ep_irq
);
  logic [1:0]        rst_sync;
  logic              rst_ns;
  logic              wr_ctrl, wr_cfg, wr_stat, wr_ien;
  logic              alloc_d, alloc_q;
  logic [SIZE_W-1:0] size_d, size_q;
  logic [BANK_W-1:0] bank_d, bank_q;
  logic [1:0]        ien_d, ien_q;
  logic              alloc_rise;
  logic              cfg_ok;
  logic [NFLAG-1:0]  hw_set, sw_clr, flags;
  logic [1:0]        toggle;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  always_comb begin
    wr_ctrl = reg_wr && (reg_addr_e'(reg_addr) == RA_CTRL);
    wr_cfg  = reg_wr && (reg_addr_e'(reg_addr) == RA_CFG);
    wr_stat = reg_wr && (reg_addr_e'(reg_addr) == RA_STAT);
    wr_ien  = reg_wr && (reg_addr_e'(reg_addr) == RA_IEN);
  end

  always_comb begin
    alloc_d = alloc_q;
    size_d  = size_q;
    bank_d  = bank_q;
    ien_d   = ien_q;
    if (wr_ctrl) alloc_d = reg_wdata[0];
    if (wr_cfg) begin
      size_d = reg_wdata[SIZE_W-1:0];
      bank_d = reg_wdata[CF_BNK0 +: BANK_W];
    end
    if (wr_ien) ien_d = reg_wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      alloc_q <= 1'b0;
      size_q  <= '0;
      bank_q  <= '0;
      ien_q   <= 2'b00;
    end else begin
      alloc_q <= alloc_d;
      size_q  <= size_d;
      bank_q  <= bank_d;
      ien_q   <= ien_d;
    end
  end

  assign alloc_rise = wr_ctrl && reg_wdata[0] && !alloc_q;

  ep_cfg_check #(
    .FIFO_BYTES(FIFO_BYTES),
    .MAX_BANKS (MAX_BANKS),
    .BASE_BYTES(BASE_BYTES)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_ns),
    .alloc_rise(alloc_rise),
    .size_code (size_q),
    .bank_sel  (bank_q),
    .cfg_ok    (cfg_ok)
  );

  always_comb begin
    hw_set         = '0;
    hw_set[FL_OVF] = ovf_evt;
    hw_set[FL_UDF] = udf_evt;
    hw_set[FL_ZLP] = zlp_evt;
    sw_clr         = {NFLAG{wr_stat}} & ~reg_wdata[ST_FLG0 +: NFLAG];
  end

  ep_sticky_flags #(.N(NFLAG)) u_flags (
    .clk   (clk),
    .rst_n (rst_ns),
    .hw_set(hw_set),
    .sw_clr(sw_clr),
    .flags (flags)
  );

  ep_toggle_track u_tog (
    .clk   (clk),
    .rst_n (rst_ns),
    .vld   (rx_tog_vld),
    .rx_tog(rx_tog),
    .toggle(toggle)
  );

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr_e'(reg_addr))
      RA_CTRL: reg_rdata[0] = alloc_q;
      RA_CFG: begin
        reg_rdata[SIZE_W-1:0]        = size_q;
        reg_rdata[CF_BNK0 +: BANK_W] = bank_q;
      end
      RA_STAT: begin
        reg_rdata[ST_OK]             = cfg_ok;
        reg_rdata[ST_FLG0 +: NFLAG]  = flags;
        reg_rdata[ST_TOG0 +: 2]      = toggle;
      end
      default: reg_rdata[1:0] = ien_q;
    endcase
  end

  assign ep_alloc = alloc_q;
  assign ep_irq   = (flags[FL_OVF] & ien_q[0]) | (flags[FL_UDF] & ien_q[1]);

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_ns)
    (ien_q == 2'b00) |-> !ep_irq); // R8
  AST_ALLOC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_ns)
    wr_ctrl |=> (ep_alloc == $past(reg_wdata[0]))); // R1
endmodule

// File: tb/ep_status_cfg_tb.sv
module ep_status_cfg_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       ovf_evt, udf_evt, zlp_evt, rx_tog_vld, rx_tog;
  logic       ep_alloc, ep_irq;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ep_status_cfg u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovf_evt(ovf_evt),
    .udf_evt(udf_evt), .zlp_evt(zlp_evt), .rx_tog_vld(rx_tog_vld),
    .rx_tog(rx_tog), .ep_alloc(ep_alloc), .ep_irq(ep_irq)
  );

  // {size code[2:0], bank field[1:0], expected valid}; 256-byte FIFO, 2 banks, 8-byte base
  localparam logic [5:0] VEC [0:7] = '{
    {3'd4, 2'd0, 1'b1},  // 128 x1
    {3'd5, 2'd1, 1'b0},  // 256 x2 over capacity
    {3'd4, 2'd1, 1'b1},  // 128 x2 exact fit
    {3'd3, 2'd2, 1'b0},  // 64 x3 too many banks
    {3'd5, 2'd0, 1'b1},  // 256 x1 exact fit
    {3'd7, 2'd0, 1'b0},  // 1024 x1
    {3'd0, 2'd1, 1'b1},  // 8 x2
    {3'd2, 2'd3, 1'b0}   // 32 x4 too many banks
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  logic [7:0] v;

  initial begin
    rst_n = 1'b0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    ovf_evt = 0; udf_evt = 0; zlp_evt = 0; rx_tog_vld = 0; rx_tog = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state: R10
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R10 reset reg", v, 8'h00);
    end
    chk("R10 reset irq/alloc", {6'd0, ep_irq, ep_alloc}, 8'h00);

    // capacity table: R2
    for (int i = 0; i < 8; i++) begin
      wr(2'd1, {2'b00, VEC[i][2:1], 1'b0, VEC[i][5:3]});
      wr(2'd0, 8'h01);
      rd(2'd0, v); chk("R1 alloc readback", v, 8'h01);
      chk("R1 ep_alloc", {7'd0, ep_alloc}, 8'h01);
      rd(2'd2, v); chk("R2 cfg valid", {7'd0, v[0]}, {7'd0, VEC[i][0]});
      wr(2'd0, 8'h00);
      rd(2'd2, v); chk("R2 hold after free", {7'd0, v[0]}, {7'd0, VEC[i][0]});
    end
    // config change without allocation rise: R2
    wr(2'd1, 8'h04);
    rd(2'd2, v); chk("R2 no recompute on cfg write", {7'd0, v[0]}, 8'h00);
    wr(2'd0, 8'h01);
    rd(2'd2, v); chk("R2 recompute on rise", {7'd0, v[0]}, 8'h01);
    wr(2'd1, 8'h37);
    wr(2'd0, 8'h01);
    rd(2'd2, v); chk("R2 no recompute while allocated", {7'd0, v[0]}, 8'h01);

    // overflow: R3
    @(negedge clk); ovf_evt = 1; @(negedge clk); ovf_evt = 0;
    rd(2'd2, v); chk("R3 ovf set", v, 8'h03);
    chk("R8 irq masked", {7'd0, ep_irq}, 8'h00);
    wr(2'd3, 8'h01);
    chk("R8 irq ovf enabled", {7'd0, ep_irq}, 8'h01);
    wr(2'd2, 8'hFF);
    rd(2'd2, v); chk("R6 write one no effect", v, 8'h03);
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R6 clear by zero", v, 8'h01);
    chk("R8 irq drops after clear", {7'd0, ep_irq}, 8'h00);

    // underflow: R4
    @(negedge clk); udf_evt = 1; @(negedge clk); udf_evt = 0;
    rd(2'd2, v); chk("R4 udf set", v, 8'h05);
    chk("R8 udf not enabled", {7'd0, ep_irq}, 8'h00);
    wr(2'd3, 8'h02);
    chk("R8 udf enabled", {7'd0, ep_irq}, 8'h01);

    // zero-length packet: R5
    @(negedge clk); zlp_evt = 1; @(negedge clk); zlp_evt = 0;
    rd(2'd2, v); chk("R5 zlp set", v, 8'h0D);
    wr(2'd2, 8'h0B);
    rd(2'd2, v); chk("R6 clear only udf", v, 8'h09);
    wr(2'd3, 8'h03);
    chk("R8 zlp raises no irq", {7'd0, ep_irq}, 8'h00);

    // same-cycle set and clear: R7
    @(negedge clk);
    ovf_evt = 1; reg_wr = 1; reg_addr = 2'd2; reg_wdata = 8'h00;
    @(negedge clk);
    ovf_evt = 0; reg_wr = 0;
    rd(2'd2, v); chk("R7 hardware set wins", v, 8'h03);
    chk("R8 irq after race", {7'd0, ep_irq}, 8'h01);

    // toggle: R9
    @(negedge clk); rx_tog_vld = 1; rx_tog = 1; @(negedge clk); rx_tog_vld = 0; rx_tog = 0;
    rd(2'd2, v); chk("R9 toggle DATA1", v, 8'h13);
    wr(2'd2, 8'h02);
    rd(2'd2, v); chk("R9 toggle read-only", v, 8'h13);
    @(negedge clk); rx_tog_vld = 1; rx_tog = 0; @(negedge clk); rx_tog_vld = 0;
    rd(2'd2, v); chk("R9 toggle DATA0", v, 8'h03);

    // reserved bits: R10, R1
    wr(2'd0, 8'hFE);
    rd(2'd0, v); chk("R1 ctrl reserved zero", v, 8'h00);
    chk("R1 ep_alloc freed", {7'd0, ep_alloc}, 8'h00);
    wr(2'd1, 8'hFF);
    rd(2'd1, v); chk("R10 cfg reserved zero", v, 8'h37);
    wr(2'd3, 8'hFC);
    rd(2'd3, v); chk("R10 ien reserved zero", v, 8'h00);
    wr(2'd0, 8'h01);
    rd(2'd2, v); chk("R2 invalid on rise", {7'd0, v[0]}, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule